// File: doc/BRIEF.md
# Key Debounce and Code Store

This block sits behind a keyboard scanner. Each time the scanner presents a row, it looks at eight return lines. It confirms any key closure across a debounce wait, then turns each accepted key into an 8-bit code. The code carries the row, the column and the shift and control modifier states. Codes go into a shared 8-entry by 8-bit memory, which a host reads through a small read port. The host also sees an occupancy and error status byte and an interrupt request.

The mode select decides how the memory is used. In keyboard mode it is a first-in first-out queue of debounced key codes. In strobed-input mode it is the same queue, but it is filled with the raw return-line byte on each rising edge of an external strobe. In sensor mode the memory becomes a row image: every scan overwrites the row picked by the scan index, and the interrupt flags any bit that changed. Scan generation, the timing prescaler and display handling belong to neighbouring blocks.

Top module: `keyscan_store`

## Requirements
- R1: A return bit at 1 means a closed switch. In keyboard mode (mode_sel 2'b00, with 2'b11 treated the same), a scan strobe that sees any closed line, while no key is being tracked, takes the lowest-numbered closed column of that row as the candidate.
- R2: A candidate is stored only if its column is still closed at the first scan of the same row after DB_TICKS debounce ticks. If it is open there, the candidate is dropped and nothing is stored.
- R3: A key code holds control in bit 7, shift in bit 6, the scan row in bits 5:3 and the column in bits 2:0. Shift and control are sampled in the confirming cycle.
- R4: An accepted key is stored once. No new candidate is taken until a scan of that row shows its column open.
- R5: In queue modes, entries read back in the order they were written. The status byte gives the count in bits 2:0 and full in bit 3; when the queue holds 8 entries the count bits read 0.
- R6: A write while full, with no read in the same cycle, is dropped and sets the overrun flag, status bit 5. The flag stays set until cleared.
- R7: A read while empty in a queue mode sets the underrun flag, status bit 4, and leaves rd_data unchanged.
- R8: A pulse on clr_err clears status bits 4 and 5 and leaves the count untouched.
- R9: In queue modes, irq equals "queue not empty".
- R10: In strobed mode (mode_sel 2'b10), each rising edge of stb_in writes ret_in as one entry. Holding stb_in high adds nothing more.
- R11: In sensor mode (mode_sel 2'b01), each scan strobe writes ret_in into the memory row given by scan_row. A read returns the row at rd_addr, and the queue count does not change.
- R12: In sensor mode, irq rises in the cycle after a scan writes a row value that differs from the stored one. It stays high until a host read in sensor mode.
- R13: rd_data changes only on the clock edge that ends a read cycle.
- R14: After reset, rd_data, status and irq are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | 00/11 keyboard, 01 sensor, 10 strobed |
| scan_row | input | 3 | Row currently scanned |
| scan_stb | input | 1 | One-cycle pulse: return lines valid for scan_row |
| db_tick | input | 1 | One-cycle debounce interval pulse |
| ret_in | input | 8 | Return lines, 1 = closed |
| shift_in | input | 1 | Shift modifier state |
| ctrl_in | input | 1 | Control modifier state |
| stb_in | input | 1 | External strobe for strobed mode |
| rd_en | input | 1 | Host read request, one cycle per read |
| rd_addr | input | 3 | Row address for sensor-mode reads |
| clr_err | input | 1 | Clears the overrun and underrun flags |
| rd_data | output | 8 | Registered read data |
| status | output | 8 | {2'b00, overrun, underrun, full, count[2:0]} |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that scan_stb and db_tick are single-cycle pulses. They also assume mode_sel does not change in the middle of a read, and that stb_in is low when reset is released, since an edge is detected against a register cleared by reset. The stimulus drives every input a fixed time after the clock edge. It changes mode only while nothing is in flight, and it pulses each strobe for exactly one cycle, except in the test that holds stb_in high on purpose. Host reads and scans are never issued in the same cycle, so the rules for which event wins when set and clear coincide are never the thing under test.

// File: rtl/ks_pkg.sv
package ks_pkg;

  localparam int ROW_W  = 3;
  localparam int COL_W  = 3;
  localparam int DATA_W = 8;
  localparam int ROWS   = 1 << ROW_W;

  typedef enum logic [1:0] {
    MODE_KEY    = 2'b00,
    MODE_SENSE  = 2'b01,
    MODE_STROBE = 2'b10,
    MODE_KEY2   = 2'b11
  } ks_mode_e;

  typedef enum logic [1:0] {
    DB_IDLE  = 2'b00,
    DB_WAIT  = 2'b01,
    DB_CHECK = 2'b10,
    DB_HELD  = 2'b11
  } ks_db_state_e;

  // lowest closed column of a return byte
  function automatic logic [COL_W-1:0] lowest_set(input logic [DATA_W-1:0] v);
    logic [COL_W-1:0] idx;
    idx = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (v[i]) idx = COL_W'(i);
    end
    return idx;
  endfunction

  // key code: ctrl, shift, row, column from high to low
  function automatic logic [DATA_W-1:0] pack_key(input logic ctl,
                                                 input logic shf,
                                                 input logic [ROW_W-1:0] row,
                                                 input logic [COL_W-1:0] col);
    return {ctl, shf, row, col};
  endfunction

  function automatic logic [DATA_W-1:0] pack_status(input logic ovr,
                                                    input logic und,
                                                    input logic full,
                                                    input logic [2:0] cnt);
    return {2'b00, ovr, und, full, cnt};
  endfunction

  function automatic logic is_key_mode(input logic [1:0] m);
    return (m == MODE_KEY) || (m == MODE_KEY2);
  endfunction

endpackage

// File: rtl/ks_debounce.sv
module ks_debounce
  import ks_pkg::*;
#(
  parameter int DB_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              scan_stb,
  input  logic [ROW_W-1:0]  scan_row,
  input  logic [DATA_W-1:0] ret_in,
  input  logic              shift_in,
  input  logic              ctrl_in,
  input  logic              db_tick,
  output logic              key_push,
  output logic [DATA_W-1:0] key_code
);

  localparam int CW = (DB_TICKS > 1) ? $clog2(DB_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(DB_TICKS - 1);

  ks_db_state_e      state_q, state_d;
  logic [ROW_W-1:0]  cand_row_q;
  logic [COL_W-1:0]  cand_col_q;
  logic [CW-1:0]     tick_cnt_q;

  logic row_match;
  logic cand_closed;
  logic new_closure;

  assign row_match   = scan_stb && (scan_row == cand_row_q);
  assign cand_closed = ret_in[cand_col_q];
  assign new_closure = scan_stb && (|ret_in);

  always_comb begin
    state_d = state_q;
    if (!enable) begin
      state_d = DB_IDLE;
    end else begin
      unique case (state_q)
        DB_IDLE:  if (new_closure) state_d = DB_WAIT;
        DB_WAIT:  if (db_tick && tick_cnt_q == LAST) state_d = DB_CHECK;
        DB_CHECK: if (row_match) state_d = cand_closed ? DB_HELD : DB_IDLE;
        DB_HELD:  if (row_match && !cand_closed) state_d = DB_IDLE;
        default:  state_d = DB_IDLE;
      endcase
    end
  end

  assign key_push = enable && (state_q == DB_CHECK) && row_match && cand_closed;
  assign key_code = pack_key(ctrl_in, shift_in, cand_row_q, cand_col_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= DB_IDLE;
      cand_row_q <= '0;
      cand_col_q <= '0;
      tick_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == DB_IDLE && enable && new_closure) begin
        cand_row_q <= scan_row;
        cand_col_q <= lowest_set(ret_in);
        tick_cnt_q <= '0;
      end else if (state_q == DB_WAIT && db_tick && tick_cnt_q != LAST) begin
        tick_cnt_q <= tick_cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ks_strobe.sv
module ks_strobe
  import ks_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              stb_in,
  input  logic [DATA_W-1:0] ret_in,
  output logic              stb_push,
  output logic [DATA_W-1:0] stb_data
);

  logic stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= stb_in;
  end

  assign stb_push = enable && stb_in && !stb_q;
  assign stb_data = ret_in;

endmodule

// File: rtl/ks_store.sv
module ks_store
  import ks_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sense_mode,
  input  logic                     push_vld,
  input  logic [DATA_W-1:0]        push_data,
  input  logic                     sen_we,
  input  logic [$clog2(DEPTH)-1:0] sen_row,
  input  logic [DATA_W-1:0]        sen_data,
  input  logic                     rd_en,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  input  logic                     clr_err,
  output logic [DATA_W-1:0]        rd_data,
  output logic [$clog2(DEPTH):0]   count,
  output logic                     full,
  output logic                     empty,
  output logic                     ovr_flag,
  output logic                     und_flag,
  output logic                     sen_irq,
  output logic                     ovr_evt,
  output logic                     und_evt
);

  localparam int PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wptr_q, rptr_q;
  logic [PTR_W:0]    count_q;

  logic [DEPTH-1:0]  row_hit;
  logic [DEPTH-1:0]  row_diff;
  logic              any_change;
  logic              fifo_rd, pop_ok, push_ok;

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    assign row_hit[g]  = sen_we && (sen_row == PTR_W'(g));
    assign row_diff[g] = row_hit[g] && (mem_q[g] != sen_data);
  end

  assign any_change = |row_diff;
  assign full       = (count_q == (PTR_W+1)'(DEPTH));
  assign empty      = (count_q == '0);
  assign count      = count_q;

  assign fifo_rd = rd_en && !sense_mode;
  assign pop_ok  = fifo_rd && !empty;
  assign und_evt = fifo_rd && empty;
  assign push_ok = push_vld && (!full || pop_ok);
  assign ovr_evt = push_vld && full && !pop_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (row_hit[i])
          mem_q[i] <= sen_data;
        else if (push_ok && wptr_q == PTR_W'(i))
          mem_q[i] <= push_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
      rd_data <= '0;
    end else begin
      if (push_ok) wptr_q <= wptr_q + 1'b1;
      if (pop_ok)  rptr_q <= rptr_q + 1'b1;
      if (push_ok && !pop_ok)      count_q <= count_q + 1'b1;
      else if (pop_ok && !push_ok) count_q <= count_q - 1'b1;
      if (rd_en && sense_mode) rd_data <= mem_q[rd_addr];
      else if (pop_ok)         rd_data <= mem_q[rptr_q];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_flag <= 1'b0;
      und_flag <= 1'b0;
      sen_irq  <= 1'b0;
    end else begin
      if (ovr_evt)      ovr_flag <= 1'b1;
      else if (clr_err) ovr_flag <= 1'b0;
      if (und_evt)      und_flag <= 1'b1;
      else if (clr_err) und_flag <= 1'b0;
      if (any_change)                sen_irq <= 1'b1;
      else if (rd_en && sense_mode)  sen_irq <= 1'b0;
    end
  end

endmodule

// File: rtl/keyscan_store.sv
module keyscan_store
  import ks_pkg::*;
#(
  parameter int DB_TICKS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  mode_sel,
  input  logic [2:0]  scan_row,
  input  logic        scan_stb,
  input  logic        db_tick,
  input  logic [7:0]  ret_in,
  input  logic        shift_in,
  input  logic        ctrl_in,
  input  logic        stb_in,
  input  logic        rd_en,
  input  logic [2:0]  rd_addr,
  input  logic        clr_err,
  output logic [7:0]  rd_data,
  output logic [7:0]  status,
  output logic        irq
);

  localparam int DEPTH = ROWS;
  localparam int PTR_W = $clog2(DEPTH);

  logic              key_en, sense_en, strobe_en;
  logic              key_push, stb_push, push_vld;
  logic [DATA_W-1:0] key_code, stb_data, push_data;
  logic [PTR_W:0]    count;
  logic              full, empty, ovr_flag, und_flag, sen_irq;
  logic              ovr_evt, und_evt;

  assign key_en    = is_key_mode(mode_sel);
  assign sense_en  = (mode_sel == MODE_SENSE);
  assign strobe_en = (mode_sel == MODE_STROBE);

  ks_debounce #(.DB_TICKS(DB_TICKS)) u_db (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (key_en),
    .scan_stb (scan_stb),
    .scan_row (scan_row),
    .ret_in   (ret_in),
    .shift_in (shift_in),
    .ctrl_in  (ctrl_in),
    .db_tick  (db_tick),
    .key_push (key_push),
    .key_code (key_code)
  );

  ks_strobe u_stb (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (strobe_en),
    .stb_in   (stb_in),
    .ret_in   (ret_in),
    .stb_push (stb_push),
    .stb_data (stb_data)
  );

  assign push_vld  = key_push || stb_push;
  assign push_data = stb_push ? stb_data : key_code;

  ks_store #(.DEPTH(DEPTH)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .sense_mode(sense_en),
    .push_vld  (push_vld),
    .push_data (push_data),
    .sen_we    (sense_en && scan_stb),
    .sen_row   (scan_row),
    .sen_data  (ret_in),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .clr_err   (clr_err),
    .rd_data   (rd_data),
    .count     (count),
    .full      (full),
    .empty     (empty),
    .ovr_flag  (ovr_flag),
    .und_flag  (und_flag),
    .sen_irq   (sen_irq),
    .ovr_evt   (ovr_evt),
    .und_evt   (und_evt)
  );

  assign status = pack_status(ovr_flag, und_flag, full, count[2:0]);
  assign irq    = sense_en ? sen_irq : !empty;

endmodule

// File: rtl/ks_checker.sv
module ks_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_sel,
  input logic       scan_stb,
  input logic [7:0] ret_in,
  input logic       rd_en,
  input logic       clr_err,
  input logic [7:0] rd_data,
  input logic [7:0] status,
  input logic       irq,
  input logic       key_push,
  input logic       push_vld,
  input logic [7:0] push_data
);

  // R9: queue-mode interrupt follows occupancy
  p_irq_fifo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != 2'b01) |-> (irq == (status[3] || status[2:0] != 3'd0)));

  // R5: full reads as count bits zero
  p_full_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    status[3] |-> (status[2:0] == 3'd0));

  // R6: write into a full queue is dropped and flagged
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_vld && status[3] && !rd_en && mode_sel != 2'b01) |=> (status[5] && status[3]));

  // R6: overrun is sticky without a clear
  p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[5] && !clr_err) |=> status[5]);

  // R7: empty read flags underrun and keeps data
  p_underrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && mode_sel != 2'b01 && status[3:0] == 4'd0) |=> (status[4] && $stable(rd_data)));

  // R8: clear removes both error flags
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_err && !push_vld && !rd_en) |=> (status[5:4] == 2'b00));

  // R1: an accepted key is a closed line seen on a keyboard-mode scan
  p_key_col_r1: assert property (@(posedge clk) disable iff (!rst_n)
    key_push |-> (scan_stb && ret_in[push_data[2:0]] && (mode_sel == 2'b00 || mode_sel == 2'b11)));

  // R10: a strobe edge yields one write only
  p_strobe_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b10 && push_vld) |=> !push_vld);

  // R12: sensor read drops the interrupt
  p_sen_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b01 && rd_en && !scan_stb) |=> (mode_sel != 2'b01 || !irq));

  // R13: read data moves only after a read
  p_rd_stable_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

bind keyscan_store ks_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_sel  (mode_sel),
  .scan_stb  (scan_stb),
  .ret_in    (ret_in),
  .rd_en     (rd_en),
  .clr_err   (clr_err),
  .rd_data   (rd_data),
  .status    (status),
  .irq       (irq),
  .key_push  (key_push),
  .push_vld  (push_vld),
  .push_data (push_data)
);

// File: tb/sim_keyscan_store.sv
`timescale 1ns/1ps
module sim_keyscan_store;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic [2:0] scan_row = '0;
  logic       scan_stb = 1'b0;
  logic       db_tick = 1'b0;
  logic [7:0] ret_in = '0;
  logic       shift_in = 1'b0;
  logic       ctrl_in = 1'b0;
  logic       stb_in = 1'b0;
  logic       rd_en = 1'b0;
  logic [2:0] rd_addr = '0;
  logic       clr_err = 1'b0;
  logic [7:0] rd_data, status;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  keyscan_store u0 (.*);

  localparam logic [7:0] VEC [8] = '{8'h81, 8'h42, 8'h24, 8'h18,
                                     8'hF0, 8'h0F, 8'hA5, 8'h5A};

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic scan(input logic [2:0] row, input logic [7:0] r);
    scan_row = row; ret_in = r; scan_stb = 1'b1;
    tick();
    scan_stb = 1'b0;
  endtask

  task automatic dbt();
    db_tick = 1'b1; tick(); db_tick = 1'b0; tick();
  endtask

  task automatic strobe(input logic [7:0] d);
    ret_in = d; stb_in = 1'b1; tick();
    stb_in = 1'b0; tick();
  endtask

  task automatic rd(input logic [2:0] a);
    rd_addr = a; rd_en = 1'b1; tick(); rd_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] st0;
    repeat (3) tick();
    chk("R14 rd_data", rd_data, 8'h00);
    chk("R14 status", status, 8'h00);
    chk("R14 irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    tick();

    // strobed-mode table walk: R10, R5, R9
    mode_sel = 2'b10; tick();
    for (int i = 0; i < 8; i++) begin
      strobe(VEC[i]);
      chk("R5 count", status, (i == 7) ? 8'h08 : 8'(i + 1));
      chk("R9 irq", {7'd0, irq}, 8'h01);
    end
    strobe(8'hEE);
    chk("R6 overrun", status, 8'h28);
    for (int i = 0; i < 8; i++) begin
      rd(3'd0);
      chk("R5 order", rd_data, VEC[i]);
    end
    chk("R9 empty", {7'd0, irq}, 8'h00);
    chk("R5 drained", status, 8'h20);
    rd(3'd0);
    chk("R7 flag", status, 8'h30);
    chk("R7 data held", rd_data, 8'h5A);
    clr_err = 1'b1; tick(); clr_err = 1'b0;
    chk("R8 clear", status, 8'h00);

    // held strobe adds one entry only
    ret_in = 8'h77; stb_in = 1'b1;
    repeat (4) tick();
    stb_in = 1'b0; tick();
    chk("R10 held", status, 8'h01);
    rd(3'd0);
    chk("R10 data", rd_data, 8'h77);
    repeat (2) tick();
    chk("R13 stable", rd_data, 8'h77);

    // sensor mode: R11, R12
    mode_sel = 2'b01; tick();
    for (int r = 0; r < 8; r++) scan(3'(r), 8'h00);
    rd(3'd0);
    chk("R12 cleared", {7'd0, irq}, 8'h00);
    st0 = status;
    scan(3'd4, 8'h3C);
    chk("R12 change", {7'd0, irq}, 8'h01);
    chk("R11 no count", status, st0);
    rd(3'd4);
    chk("R11 row", rd_data, 8'h3C);
    chk("R12 read clr", {7'd0, irq}, 8'h00);
    scan(3'd4, 8'h3C);
    chk("R12 same", {7'd0, irq}, 8'h00);
    scan(3'd2, 8'h01);
    chk("R12 again", {7'd0, irq}, 8'h01);
    rd(3'd2);
    chk("R11 row2", rd_data, 8'h01);
    rd(3'd4);
    chk("R11 row4 kept", rd_data, 8'h3C);

    // keyboard mode: R1..R4
    mode_sel = 2'b00; tick();
    shift_in = 1'b1; ctrl_in = 1'b0;
    scan(3'd3, 8'h20);
    dbt(); dbt();
    scan(3'd1, 8'h00);
    chk("R2 other row", status, 8'h00);
    scan(3'd3, 8'h20);
    chk("R2 accepted", status, 8'h01);
    chk("R9 key irq", {7'd0, irq}, 8'h01);
    rd(3'd0);
    chk("R3 code", rd_data, 8'h5D);
    scan(3'd3, 8'h20);
    dbt(); dbt();
    scan(3'd3, 8'h20);
    chk("R4 held", status, 8'h00);
    scan(3'd3, 8'h00);
    // bounce: released before confirm
    scan(3'd2, 8'h01);
    dbt(); dbt();
    scan(3'd2, 8'h00);
    chk("R2 bounce", status, 8'h00);
    // lowest column and control
    shift_in = 1'b0; ctrl_in = 1'b1;
    mode_sel = 2'b11; tick();
    scan(3'd6, 8'hA0);
    dbt();
    scan(3'd6, 8'hA0);
    chk("R2 early", status, 8'h00);
    dbt();
    scan(3'd6, 8'hA0);
    chk("R1 accepted", status, 8'h01);
    rd(3'd0);
    chk("R1 R3 code", rd_data, 8'hB5);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule